// File: doc/BRIEF.md
# SD Command Response Status Decoder

This block sits inside an SD/MMC host controller between the register file and the card-side command engine. Software writes a 16-bit command word and a 32-bit argument (as two separate 16-bit halves). When the controller is enabled, the block issues the command to the card side. The card side later hands back the whole response as a byte array together with the number of bytes it received.

The block sorts the response by its expected type and decides whether the response was too short. In that case it records a timeout. Otherwise it checks the card status for errors, tracks the operating-conditions busy bit and packs the bytes into eight 16-bit response words. It raises the completion bits in a write-one-to-clear status register. For addressed data-transfer commands it also emits a one-cycle start pulse with the transfer direction, so a data path can begin its phase.

Top module: `sd_cmd_resp_decoder`

## Requirements
- R1: A command write while `ctrl_enable` is low is ignored: no card request, no transfer pulse, no change to status or response words.
- R2: An accepted command write sets all eight response words to zero in the cycle after the write.
- R3: An accepted command with the init flag (bit 7) set and index 0 sets only status bit 0. It makes no card request and no transfer pulse.
- R4: Command word fields are: index in bits 5:0, response type in bits 10:8, busy flag in bit 11, command type in bits 13:12 and direction in bit 15. Response type 1 with the busy flag set is issued as the busy-signalling variant, and `card_busy_exp` is high while that command is outstanding.
- R5: Response type codes are 0 none, 1 short status, 2 long, 3 operating conditions and 6 published address; codes 4, 5 and 7 act as none. Types 1, 3 and 6 need at least 4 response bytes and type 2 needs 16. Fewer bytes set status bit 7, store no response words and do not set bit 0.
- R6: For type 1, the 32-bit status made from bytes 0..3 (byte 0 most significant) is ANDed with `ERR_MASK_R1`. A nonzero result sets status bit 14. Every other completion clears bit 14, unless R7 applies.
- R7: For type 6, the 16-bit value {byte 2, byte 3} is ANDed with `ERR_MASK_R6`, and a nonzero result sets status bit 14.
- R8: For type 3 without timeout, status bit 12 is set when bit 7 of byte 0 is clear and cleared when it is set.
- R9: A completion without timeout sets status bit 0. If the command index equals `STOP_IDX` (12), it sets bits 0 and 2.
- R10: On a completion without timeout for types 1, 2, 3 or 6, response word i holds {byte 2(7-i), byte 2(7-i)+1}, so the first byte pair lands in the highest word.
- R11: The argument low and high halves are written by separate strobes, and each write leaves the other half unchanged.
- R12: An accepted non-init command of command type 3 gives a one-cycle `xfer_start` pulse, coincident with `card_req`, and `xfer_dir` equals bit 15 of the command.
- R13: Writing `stat_clr_wr` clears the status bits that are set in `stat_clr_mask` and leaves the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_enable | input | 1 | Controller enable; gates command writes |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_wdata | input | 16 | Command word |
| arg_lo_wr | input | 1 | Argument low-half write strobe |
| arg_hi_wr | input | 1 | Argument high-half write strobe |
| arg_wdata | input | 16 | Argument half data |
| stat_clr_wr | input | 1 | Status clear strobe |
| stat_clr_mask | input | 16 | Bits of status to clear |
| card_req | output | 1 | One-cycle command request to the card side |
| card_cmd_idx | output | 6 | Index of the outstanding command |
| card_arg | output | 32 | Current argument |
| card_busy_exp | output | 1 | Outstanding command is the busy-signalling short type |
| card_rsp_valid | input | 1 | Card side has a response |
| card_rsp_len | input | LENW (5) | Number of response bytes received |
| card_rsp_bytes | input | 16*NWORDS (128) | Response bytes, byte k at bits 8k+7:8k |
| status | output | 16 | Status register |
| rsp_words | output | 16*NWORDS (128) | Response words, word i at bits 16i+15:16i |
| xfer_start | output | 1 | Data-phase start pulse |
| xfer_dir | output | 1 | Data-phase direction |

## Verification
The hardest states to reach are the ones where a response is exactly one byte short of its type's minimum. They are also the ones where status bits survive from an earlier command, such as the error bit 14 or the busy bit 12, and a later completion must clear them. The bench sweeps every response-type code with and without the busy flag, at lengths on both sides of 4 and 16. It uses byte patterns chosen so that the masked status is clean for some types and in error for others. It then runs directed pairs of commands without a status clear between them, so that stale bits meet their clearing case.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;

    localparam logic [2:0] RT_NONE = 3'd0;
    localparam logic [2:0] RT_R1   = 3'd1;
    localparam logic [2:0] RT_R2   = 3'd2;
    localparam logic [2:0] RT_R3   = 3'd3;
    localparam logic [2:0] RT_R6   = 3'd6;

    localparam logic [1:0] CT_ADTC = 2'd3;

    localparam int ST_DONE  = 0;
    localparam int ST_STOP  = 2;
    localparam int ST_TMO   = 7;
    localparam int ST_OCRB  = 12;
    localparam int ST_CERR  = 14;

    typedef struct packed {
        logic       dir;
        logic       rsvd14;
        logic [1:0] ctype;
        logic       busy;
        logic [2:0] rtype;
        logic       init;
        logic       rsvd6;
        logic [5:0] idx;
    } cmd_word_t;

    typedef struct packed {
        logic timeout;
        logic card_err;
        logic ocr_set;
        logic ocr_clr;
        logic store;
    } rsp_class_t;

endpackage

// File: rtl/sd_rsp_classify.sv
module sd_rsp_classify
    import sd_cmd_pkg::*;
#(
    parameter int          LENW        = 5,
    parameter int          LONG_LEN    = 16,
    parameter logic [31:0] ERR_MASK_R1 = 32'hFDF9_0000,
    parameter logic [15:0] ERR_MASK_R6 = 16'hE008
) (
    input  logic [2:0]      rtype,
    input  logic [LENW-1:0] rsp_len,
    input  logic [31:0]     head,
    output rsp_class_t      cls
);
    localparam logic [LENW-1:0] SHORT_MIN = LENW'(4);
    localparam logic [LENW-1:0] LONG_MIN  = LENW'(LONG_LEN);

    always_comb begin
        cls = '0;
        unique case (rtype)
            RT_R1: begin
                cls.timeout  = rsp_len < SHORT_MIN;
                cls.card_err = !cls.timeout && ((head & ERR_MASK_R1) != 32'd0);
                cls.store    = !cls.timeout;
            end
            RT_R2: begin
                cls.timeout = rsp_len < LONG_MIN;
                cls.store   = !cls.timeout;
            end
            RT_R3: begin
                cls.timeout = rsp_len < SHORT_MIN;
                cls.ocr_set = !cls.timeout && !head[31];
                cls.ocr_clr = !cls.timeout && head[31];
                cls.store   = !cls.timeout;
            end
            RT_R6: begin
                cls.timeout  = rsp_len < SHORT_MIN;
                cls.card_err = !cls.timeout && ((head[15:0] & ERR_MASK_R6) != 16'd0);
                cls.store    = !cls.timeout;
            end
            default: cls = '0;
        endcase
    end
endmodule

// File: rtl/sd_rsp_pack.sv
module sd_rsp_pack #(
    parameter int NWORDS = 8,
    localparam int W = 16 * NWORDS
) (
    input  logic [W-1:0] bytes_in,
    output logic [W-1:0] words_out
);
    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        localparam int HI = 2 * (NWORDS - 1 - w);
        assign words_out[16*w +: 16] = {bytes_in[8*HI +: 8], bytes_in[8*(HI+1) +: 8]};
    end
endmodule

// File: rtl/sd_cmd_resp_decoder.sv
module sd_cmd_resp_decoder
    import sd_cmd_pkg::*;
#(
    parameter int          NWORDS      = 8,
    parameter logic [5:0]  STOP_IDX    = 6'd12,
    parameter logic [31:0] ERR_MASK_R1 = 32'hFDF9_0000,
    parameter logic [15:0] ERR_MASK_R6 = 16'hE008,
    localparam int NBYTES = 2 * NWORDS,
    localparam int LENW   = $clog2(NBYTES + 1),
    localparam int RSPW   = 16 * NWORDS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ctrl_enable,
    input  logic            cmd_wr,
    input  logic [15:0]     cmd_wdata,
    input  logic            arg_lo_wr,
    input  logic            arg_hi_wr,
    input  logic [15:0]     arg_wdata,
    input  logic            stat_clr_wr,
    input  logic [15:0]     stat_clr_mask,
    output logic            card_req,
    output logic [5:0]      card_cmd_idx,
    output logic [31:0]     card_arg,
    output logic            card_busy_exp,
    input  logic            card_rsp_valid,
    input  logic [LENW-1:0] card_rsp_len,
    input  logic [RSPW-1:0] card_rsp_bytes,
    output logic [15:0]     status,
    output logic [RSPW-1:0] rsp_words,
    output logic            xfer_start,
    output logic            xfer_dir
);
    typedef struct packed {
        logic            pend;
        logic            busy_exp;
        logic            req;
        logic            xs;
        logic            xd;
        logic [5:0]      idx;
        logic [2:0]      rtype;
        logic [31:0]     arg;
        logic [15:0]     stat;
        logic [RSPW-1:0] rsp;
    } state_t;

    state_t q, d;

    cmd_word_t cw;
    assign cw = cmd_word_t'(cmd_wdata);

    logic unused_rsvd;
    assign unused_rsvd = cw.rsvd14 ^ cw.rsvd6;

    logic       pend;
    logic [2:0] rtype;
    assign pend  = q.pend;
    assign rtype = q.rtype;

    rsp_class_t      cls;
    logic [RSPW-1:0] packed_words;

    sd_rsp_classify #(
        .LENW(LENW), .LONG_LEN(NBYTES),
        .ERR_MASK_R1(ERR_MASK_R1), .ERR_MASK_R6(ERR_MASK_R6)
    ) u_classify (
        .rtype  (q.rtype),
        .rsp_len(card_rsp_len),
        .head   ({card_rsp_bytes[7:0], card_rsp_bytes[15:8],
                  card_rsp_bytes[23:16], card_rsp_bytes[31:24]}),
        .cls    (cls)
    );

    sd_rsp_pack #(.NWORDS(NWORDS)) u_pack (
        .bytes_in (card_rsp_bytes),
        .words_out(packed_words)
    );

    logic accept;
    assign accept = cmd_wr && ctrl_enable && !q.pend;

    always_comb begin
        d     = q;
        d.req = 1'b0;
        d.xs  = 1'b0;

        if (arg_lo_wr) d.arg[15:0]  = arg_wdata;
        if (arg_hi_wr) d.arg[31:16] = arg_wdata;

        if (stat_clr_wr) d.stat = q.stat & ~stat_clr_mask;

        if (accept) begin
            d.rsp = '0;
            if (cw.init && cw.idx == 6'd0) begin
                d.stat[ST_DONE] = 1'b1;
            end else begin
                d.pend     = 1'b1;
                d.req      = 1'b1;
                d.idx      = cw.idx;
                d.rtype    = cw.rtype;
                d.busy_exp = cw.busy && (cw.rtype == RT_R1);
                if (cw.ctype == CT_ADTC) begin
                    d.xs = 1'b1;
                    d.xd = cw.dir;
                end
            end
        end else if (q.pend && card_rsp_valid) begin
            d.pend           = 1'b0;
            d.busy_exp       = 1'b0;
            d.stat[ST_CERR]  = cls.card_err;
            if (cls.ocr_set) d.stat[ST_OCRB] = 1'b1;
            if (cls.ocr_clr) d.stat[ST_OCRB] = 1'b0;
            if (cls.timeout) begin
                d.stat[ST_TMO] = 1'b1;
            end else begin
                d.stat[ST_DONE] = 1'b1;
                if (q.idx == STOP_IDX) d.stat[ST_STOP] = 1'b1;
            end
            if (cls.store) d.rsp = packed_words;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign card_req      = q.req;
    assign card_cmd_idx  = q.idx;
    assign card_arg      = q.arg;
    assign card_busy_exp = q.busy_exp;
    assign status        = q.stat;
    assign rsp_words     = q.rsp;
    assign xfer_start    = q.xs;
    assign xfer_dir      = q.xd;
endmodule

// File: rtl/sd_cmd_resp_decoder_chk.sv
module sd_cmd_resp_decoder_chk #(
    parameter int LENW = 5,
    parameter int RSPW = 128
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ctrl_enable,
    input logic            cmd_wr,
    input logic [15:0]     cmd_wdata,
    input logic            card_req,
    input logic            xfer_start,
    input logic            card_rsp_valid,
    input logic [LENW-1:0] card_rsp_len,
    input logic            pend,
    input logic [2:0]      rtype,
    input logic [15:0]     status,
    input logic [RSPW-1:0] rsp_words
);
    assert_disabled_cmd_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !ctrl_enable) |=> (!card_req && !xfer_start));

    assert_issue_zeroes_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && ctrl_enable && !pend) |=> (rsp_words == '0));

    assert_init_cmd0_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && ctrl_enable && !pend && cmd_wdata[7] && cmd_wdata[5:0] == 6'd0)
        |=> (!card_req && !xfer_start && status[0]));

    assert_short_timeout_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && card_rsp_valid && rtype == 3'd1 && card_rsp_len < LENW'(4))
        |=> status[7]);

    assert_completion_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && card_rsp_valid) |=> !pend);

    assert_xfer_with_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |-> card_req);
endmodule

bind sd_cmd_resp_decoder sd_cmd_resp_decoder_chk #(.LENW(LENW), .RSPW(RSPW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ctrl_enable   (ctrl_enable),
    .cmd_wr        (cmd_wr),
    .cmd_wdata     (cmd_wdata),
    .card_req      (card_req),
    .xfer_start    (xfer_start),
    .card_rsp_valid(card_rsp_valid),
    .card_rsp_len  (card_rsp_len),
    .pend          (pend),
    .rtype         (rtype),
    .status        (status),
    .rsp_words     (rsp_words)
);

// File: tb/sd_cmd_resp_decoder_tb.sv
module sd_cmd_resp_decoder_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ctrl_enable = 1'b0;
    logic         cmd_wr = 1'b0;
    logic [15:0]  cmd_wdata = '0;
    logic         arg_lo_wr = 1'b0;
    logic         arg_hi_wr = 1'b0;
    logic [15:0]  arg_wdata = '0;
    logic         stat_clr_wr = 1'b0;
    logic [15:0]  stat_clr_mask = '0;
    logic         card_req;
    logic [5:0]   card_cmd_idx;
    logic [31:0]  card_arg;
    logic         card_busy_exp;
    logic         card_rsp_valid = 1'b0;
    logic [4:0]   card_rsp_len = '0;
    logic [127:0] card_rsp_bytes = '0;
    logic [15:0]  status;
    logic [127:0] rsp_words;
    logic         xfer_start;
    logic         xfer_dir;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    sd_cmd_resp_decoder u_dut (.*);

    task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] bval(int seed, int k);
        logic [31:0] head;
        case (seed)
            0: head = 32'h0000_0000;
            1: head = 32'h8000_0000;
            2: head = 32'h0200_E000;
            default: head = 32'h7F35_10A9;
        endcase
        if (k < 4) return head[8*(3-k) +: 8];
        return 8'((seed * 91 + k * 29 + 7) & 255);
    endfunction

    function automatic logic [127:0] mkbytes(int seed);
        logic [127:0] b;
        for (int k = 0; k < 16; k++) b[8*k +: 8] = bval(seed, k);
        return b;
    endfunction

    function automatic logic [127:0] exp_words(int seed);
        logic [127:0] w;
        for (int i = 0; i < 8; i++)
            w[16*i +: 16] = {bval(seed, 2*(7-i)), bval(seed, 2*(7-i)+1)};
        return w;
    endfunction

    task automatic step();
        @(negedge clk);
    endtask

    task automatic clear_status(logic [15:0] m);
        stat_clr_wr = 1'b1; stat_clr_mask = m;
        step();
        stat_clr_wr = 1'b0;
    endtask

    task automatic issue(logic [15:0] c);
        cmd_wdata = c; cmd_wr = 1'b1;
        step();
        cmd_wr = 1'b0;
    endtask

    task automatic respond(int len, int seed);
        card_rsp_valid = 1'b1; card_rsp_len = 5'(len); card_rsp_bytes = mkbytes(seed);
        step();
        card_rsp_valid = 1'b0;
    endtask

    function automatic logic [15:0] mkcmd(logic dir, logic [1:0] ct, logic busy,
                                          logic [2:0] rt, logic init, logic [5:0] idx);
        return {dir, 1'b0, ct, busy, rt, init, 1'b0, idx};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        step(); step();
        rst_n = 1'b1;
        step();
        chk("reset status", 128'(status), 128'h0);
        chk("reset rsp", rsp_words, 128'h0);
        chk("reset req", 128'(card_req), 128'h0);

        // R11: argument halves
        arg_wdata = 16'h1234; arg_lo_wr = 1'b1; step(); arg_lo_wr = 1'b0;
        arg_wdata = 16'hABCD; arg_hi_wr = 1'b1; step(); arg_hi_wr = 1'b0;
        chk("R11 both halves", 128'(card_arg), 128'hABCD1234);
        arg_wdata = 16'h5678; arg_lo_wr = 1'b1; step(); arg_lo_wr = 1'b0;
        chk("R11 low keeps high", 128'(card_arg), 128'hABCD5678);

        // R1: disabled command ignored
        issue(mkcmd(1'b0, 2'd3, 1'b0, 3'd1, 1'b0, 6'd5));
        chk("R1 no req", 128'(card_req), 128'h0);
        chk("R1 no xfer", 128'(xfer_start), 128'h0);
        step();
        chk("R1 status unchanged", 128'(status), 128'h0);

        ctrl_enable = 1'b1;
        // R3: init command 0
        issue(mkcmd(1'b1, 2'd3, 1'b0, 3'd1, 1'b1, 6'd0));
        chk("R3 no req", 128'(card_req), 128'h0);
        chk("R3 no xfer", 128'(xfer_start), 128'h0);
        chk("R3 status", 128'(status), 128'h0001);
        step();
        chk("R3 still idle", 128'(card_req), 128'h0);

        // R9 + R13: stop index then partial clear
        clear_status(16'hFFFF);
        issue(mkcmd(1'b0, 2'd0, 1'b0, 3'd1, 1'b0, 6'd12));
        respond(4, 0);
        chk("R9 stop bits", 128'(status), 128'h0005);
        clear_status(16'h0004);
        chk("R13 partial clear", 128'(status), 128'h0001);

        // R6: error bit set, then cleared by a clean response without a clear
        issue(mkcmd(1'b0, 2'd0, 1'b0, 3'd1, 1'b0, 6'd3));
        respond(4, 1);
        chk("R6 error set", 128'(status[14]), 128'h1);
        issue(mkcmd(1'b0, 2'd0, 1'b0, 3'd1, 1'b0, 6'd3));
        respond(4, 2);
        chk("R6 error cleared", 128'(status[14]), 128'h0);

        // R8: busy bit set then cleared
        issue(mkcmd(1'b0, 2'd0, 1'b0, 3'd3, 1'b0, 6'd1));
        respond(4, 0);
        chk("R8 ocr set", 128'(status[12]), 128'h1);
        issue(mkcmd(1'b0, 2'd0, 1'b0, 3'd3, 1'b0, 6'd1));
        respond(4, 1);
        chk("R8 ocr cleared", 128'(status[12]), 128'h0);

        // Sweep: R2 R4 R5 R6 R7 R8 R9 R10 R12
        begin
            int v = 0;
            for (int seed = 0; seed < 4; seed++)
            for (int t = 0; t < 8; t++)
            for (int b = 0; b < 2; b++)
            for (int li = 0; li < 5; li++) begin
                int lens[5] = '{0, 3, 4, 15, 16};
                int len = lens[li];
                logic [5:0] idx = (v % 5 == 0) ? 6'd12 : 6'(1 + v % 40);
                logic [1:0] ct = 2'(v % 4);
                logic dir = v[0] ^ v[2];
                logic [31:0] head = {bval(seed,0), bval(seed,1), bval(seed,2), bval(seed,3)};
                logic tmo, has_rsp;
                logic [15:0] es;
                v++;
                clear_status(16'hFFFF);
                issue(mkcmd(dir, ct, b[0], 3'(t), 1'b0, idx));
                chk("R2 rsp zeroed", rsp_words, 128'h0);
                chk("R4 request", 128'(card_req), 128'h1);
                chk("R4 index", 128'(card_cmd_idx), 128'(idx));
                chk("R4 busy variant", 128'(card_busy_exp), 128'(b == 1 && t == 1));
                chk("R12 start", 128'(xfer_start), 128'(ct == 2'd3));
                if (ct == 2'd3) chk("R12 dir", 128'(xfer_dir), 128'(dir));
                respond(len, seed);
                has_rsp = (t == 1 || t == 2 || t == 3 || t == 6);
                tmo = ((t == 1 || t == 3 || t == 6) && len < 4) || (t == 2 && len < 16);
                es = '0;
                if (tmo) es[7] = 1'b1;
                else begin
                    if (t == 1 && (head & 32'hFDF9_0000) != 0) es[14] = 1'b1;
                    if (t == 6 && (head[15:0] & 16'hE008) != 0) es[14] = 1'b1;
                    if (t == 3 && !head[31]) es[12] = 1'b1;
                    es[0] = 1'b1;
                    if (idx == 6'd12) es[2] = 1'b1;
                end
                chk("R5 R6 R7 R8 R9 status", 128'(status), 128'(es));
                chk("R10 rsp words", rsp_words,
                    (has_rsp && !tmo) ? exp_words(seed) : 128'h0);
                chk("R4 busy drops", 128'(card_busy_exp), 128'h0);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule